// File: doc/BRIEF.md
# Bidirectional Latched and Registered Bus Transceiver

This block joins two 18-bit buses, an A port and a B port, and passes data between them without inversion. Each of the two directions has its own storage stage. While the stage's latch enable is high it is transparent and the destination port follows the source port. While the latch enable is low it holds its contents, and it can load new data on a rising edge of its own clock, provided that direction's clock enable is asserted.

Each direction has an active-low output enable that decides whether the destination port is driven. The ports are bidirectional pins. A per-bit drive-enable output is brought out next to each port, so that a pad ring or a testbench can see which bits the block is driving. An active-low asynchronous reset clears both stages and keeps both ports released for as long as it is held.

Top module: `bus_xcvr`

## Requirements
- R1: Data moves 18 bits wide in both directions, and every bit arrives unchanged (non-inverting). Bit n of the source port lands on bit n of the destination port.
- R2: While `ab_le` is 1, the A-to-B stage is transparent and the driven `b_io` equals `a_io`.
- R3: While `ab_le` is 0 and no enabled rising edge of `ab_clk` occurs, the value held for `b_io` does not change, whatever `a_io` does.
- R4: While `ab_le` is 0 and `ab_ce_n` is 0, a rising edge of `ab_clk` loads the value of `a_io`, and that value appears on `b_io` right after the edge.
- R5: `ab_oe_n` is active low. At 1, all bits of `b_drv_en` are 0 and the block releases `b_io`. At 0, all bits of `b_drv_en` are 1. The storage keeps loading while the port is released.
- R6: A rising edge of a direction's clock is ignored while that direction's clock enable (`ab_ce_n` or `ba_ce_n`) is 1.
- R7: The B-to-A direction behaves as R2 to R6 describe, using `ba_le`, `ba_clk`, `ba_ce_n` and `ba_oe_n`, with data taken from `b_io` and driven onto `a_io`. Its drive enable is `a_drv_en`.
- R8: While `rst_n` is 0, `a_drv_en` and `b_drv_en` are all 0, whatever the output enables are. After `rst_n` is released, both stages hold 0.
- R9: A rising clock edge that arrives while the latch enable is 1 has no effect beyond the transparent path. Once the latch enable falls, the value present at the fall is held.
- R10: The block does not arbitrate. With both output enables at 0, both ports are driven, each with its own direction's stored data. The testbench reports this combination as an illegal configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_le | input | 1 | A-to-B latch enable, transparent when 1 |
| ab_clk | input | 1 | A-to-B load clock, rising edge |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_oe_n | input | 1 | B port output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, transparent when 1 |
| ba_clk | input | 1 | B-to-A load clock, rising edge |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_oe_n | input | 1 | A port output enable, active low |
| a_io | inout | 18 | A port bus |
| b_io | inout | 18 | B port bus |
| a_drv_en | output | 18 | Per-bit flag that the block drives a_io |
| b_drv_en | output | 18 | Per-bit flag that the block drives b_io |

## Verification
The output enables, the reset and the transparent path act with no clock. A clocked load takes effect at the rising edge of the direction clock itself. No result waits a whole bench cycle. In each 8 ns bench cycle the controls change at the falling edge of the bench clock, the source data follows 1 ns later, and any direction clock pulse starts 1 ns after that. The ports are sampled 2 ns after the last change, so every check falls inside the cycle of its own stimulus and ahead of the next one. The data is moved 1 ns away from each latch-enable change, so the value held when the enable falls is never left to process ordering.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Default bus width of the transceiver.
  localparam int unsigned XCVR_W = 18;

  // Which storage element last took data while the latch enable was low.
  typedef enum logic {
    SRC_LATCH = 1'b0,
    SRC_EDGE  = 1'b1
  } store_src_e;
endpackage

// File: rtl/xcvr_store.sv
`timescale 1ns/1ps
// One direction's storage stage: a level-sensitive latch and an
// edge-triggered register. A toggle pair records which of the two wrote last.
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic         ce_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic         cap;
  logic [W-1:0] edge_q;
  logic [W-1:0] edge_nxt;
  logic [W-1:0] lat_q;
  logic         tog_e;
  logic         tog_e_nxt;
  logic         tog_l;
  store_src_e   src;

  // Edge loading is only meaningful while the latch is closed.
  assign cap = ~ce_n & ~le;

  always_comb begin
    edge_nxt  = edge_q;
    tog_e_nxt = tog_e;
    if (cap) begin
      edge_nxt  = d;
      tog_e_nxt = ~tog_l;   // mark the register as the newest copy
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= '0;
      tog_e  <= 1'b0;
    end else begin
      edge_q <= edge_nxt;
      tog_e  <= tog_e_nxt;
    end
  end

  // Transparent latch. An open latch also marks itself as the newest copy.
  always_latch begin
    if (!rst_n) begin
      lat_q <= '0;
      tog_l <= 1'b0;
    end else if (le) begin
      lat_q <= d;
      tog_l <= tog_e;
    end
  end

  assign src = store_src_e'(tog_e ^ tog_l);

  always_comb begin
    if (le) begin
      q = d;
    end else if (src == SRC_EDGE) begin
      q = edge_q;
    end else begin
      q = lat_q;
    end
  end

endmodule

// File: rtl/xcvr_oe.sv
`timescale 1ns/1ps
// Per-bit drive enable for one port. Reset overrides the output enable.
module xcvr_oe
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         rst_n,
  input  logic         oe_n,
  output logic [W-1:0] en
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign en[i] = rst_n & ~oe_n;
  end

endmodule

// File: rtl/bus_xcvr.sv
`timescale 1ns/1ps
module bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         rst_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_ce_n,
  input  logic         ab_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_ce_n,
  input  logic         ba_oe_n,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io,
  output logic [W-1:0] a_drv_en,
  output logic [W-1:0] b_drv_en
);

  logic [W-1:0] q_ab;
  logic [W-1:0] q_ba;

  xcvr_store #(.W(W)) u_store_ab (
    .clk   (ab_clk),
    .rst_n (rst_n),
    .le    (ab_le),
    .ce_n  (ab_ce_n),
    .d     (a_io),
    .q     (q_ab)
  );

  xcvr_store #(.W(W)) u_store_ba (
    .clk   (ba_clk),
    .rst_n (rst_n),
    .le    (ba_le),
    .ce_n  (ba_ce_n),
    .d     (b_io),
    .q     (q_ba)
  );

  xcvr_oe #(.W(W)) u_oe_b (
    .rst_n (rst_n),
    .oe_n  (ab_oe_n),
    .en    (b_drv_en)
  );

  xcvr_oe #(.W(W)) u_oe_a (
    .rst_n (rst_n),
    .oe_n  (ba_oe_n),
    .en    (a_drv_en)
  );

  // Tri-state pad drivers, one per bit.
  for (genvar i = 0; i < W; i++) begin : g_pad
    assign b_io[i] = b_drv_en[i] ? q_ab[i] : 1'bz;
    assign a_io[i] = a_drv_en[i] ? q_ba[i] : 1'bz;
  end

endmodule

// File: rtl/xcvr_chk.sv
`timescale 1ns/1ps
module xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         rst_n,
  input logic         ab_le,
  input logic         ab_clk,
  input logic         ab_oe_n,
  input logic         ba_le,
  input logic         ba_clk,
  input logic         ba_oe_n,
  input logic [W-1:0] a_io,
  input logic [W-1:0] b_io,
  input logic [W-1:0] a_drv_en,
  input logic [W-1:0] b_drv_en
);

  // R2: an open A-to-B latch makes B follow A
  a_r2_ab_follow: assert property (@(posedge ab_clk) disable iff (!rst_n)
    (ab_le && !ab_oe_n) |-> (b_io == a_io));

  // R7: an open B-to-A latch makes A follow B
  a_r7_ba_follow: assert property (@(posedge ba_clk) disable iff (!rst_n)
    (ba_le && !ba_oe_n) |-> (a_io == b_io));

  // R5: a high output enable releases every B bit
  a_r5_b_released: assert property (@(posedge ab_clk) disable iff (!rst_n)
    ab_oe_n |-> (b_drv_en == '0));

  // R7: a high output enable releases every A bit
  a_r7_a_released: assert property (@(posedge ba_clk) disable iff (!rst_n)
    ba_oe_n |-> (a_drv_en == '0));

  // R8: this property checks reset itself, so it is not disabled by reset
  a_r8_reset_released: assert property (@(posedge ab_clk)
    !rst_n |-> (a_drv_en == '0 && b_drv_en == '0));

endmodule

bind bus_xcvr xcvr_chk #(.W(W)) u_xcvr_chk (
  .rst_n    (rst_n),
  .ab_le    (ab_le),
  .ab_clk   (ab_clk),
  .ab_oe_n  (ab_oe_n),
  .ba_le    (ba_le),
  .ba_clk   (ba_clk),
  .ba_oe_n  (ba_oe_n),
  .a_io     (a_io),
  .b_io     (b_io),
  .a_drv_en (a_drv_en),
  .b_drv_en (b_drv_en)
);

// File: tb/test_bus_xcvr.sv
`timescale 1ns/1ps
module test_bus_xcvr;
  localparam int W = 18;
  localparam int NV = 12;

  typedef struct packed {
    logic         le;
    logic         ce_n;
    logic         oe_n;
    logic         pulse;
    logic [W-1:0] a;
    logic [W-1:0] exp_b;
    logic         exp_off;
  } vec_t;

  // {le, ce_n, oe_n, pulse, a, expected b, expect released}
  localparam logic [40:0] VECS [0:NV-1] = '{
    {1'b0, 1'b1, 1'b0, 1'b0, 18'h3FFFF, 18'h00000, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 18'h12345, 18'h12345, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 18'h2AAAA, 18'h2AAAA, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 18'h15555, 18'h2AAAA, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b1, 18'h15555, 18'h2AAAA, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b1, 18'h15555, 18'h15555, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 18'h00F0F, 18'h15555, 1'b0},
    {1'b0, 1'b0, 1'b1, 1'b0, 18'h00F0F, 18'h00000, 1'b1},
    {1'b0, 1'b0, 1'b1, 1'b1, 18'h3C3C3, 18'h00000, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b0, 18'h00000, 18'h3C3C3, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b1, 18'h0F0F0, 18'h0F0F0, 1'b0},
    {1'b0, 1'b1, 1'b0, 1'b0, 18'h11111, 18'h0F0F0, 1'b0}
  };

  logic clk;
  logic rst_n;
  logic ab_le, ab_clk, ab_ce_n, ab_oe_n;
  logic ba_le, ba_clk, ba_ce_n, ba_oe_n;
  logic [W-1:0] a_drv, b_drv;
  logic a_den, b_den;
  wire  [W-1:0] a_io, b_io;
  logic [W-1:0] a_drv_en, b_drv_en;
  int n_cmp;
  int n_bad;
  logic illegal_seen;

  assign a_io = a_den ? a_drv : {W{1'bz}};
  assign b_io = b_den ? b_drv : {W{1'bz}};

  bus_xcvr #(.W(W)) i_bus_xcvr (
    .rst_n    (rst_n),
    .ab_le    (ab_le),
    .ab_clk   (ab_clk),
    .ab_ce_n  (ab_ce_n),
    .ab_oe_n  (ab_oe_n),
    .ba_le    (ba_le),
    .ba_clk   (ba_clk),
    .ba_ce_n  (ba_ce_n),
    .ba_oe_n  (ba_oe_n),
    .a_io     (a_io),
    .b_io     (b_io),
    .a_drv_en (a_drv_en),
    .b_drv_en (b_drv_en)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // R10: flag the illegal case where both ports are driven together
  always @(negedge clk) begin
    if (rst_n === 1'b1 && a_drv_en != '0 && b_drv_en != '0 && !illegal_seen) begin
      illegal_seen = 1'b1;
      $display("NOTE: illegal configuration, both directions drive at %0t", $time);
    end
  end

  function automatic string row_tag(input int i);
    case (i)
      0:  row_tag = "R8 storage cleared by reset";
      1:  row_tag = "R2 transparent path";
      2:  row_tag = "R1 alternating bits through latch";
      3:  row_tag = "R3 hold after latch enable falls";
      4:  row_tag = "R6 edge ignored while clock enable high";
      5:  row_tag = "R4 load on rising edge";
      6:  row_tag = "R3 hold without edge";
      7:  row_tag = "R5 port released";
      8:  row_tag = "R5 load while released";
      9:  row_tag = "R5 loaded data shown when enabled";
      10: row_tag = "R9 edge during transparency";
      default: row_tag = "R9 hold after edge during transparency";
    endcase
  endfunction

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_ab();
    #1 ab_clk = 1'b1;
    #2 ab_clk = 1'b0;
  endtask

  task automatic pulse_ba();
    #1 ba_clk = 1'b1;
    #2 ba_clk = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #400000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    vec_t v;
    n_cmp = 0;
    n_bad = 0;
    illegal_seen = 1'b0;
    rst_n = 1'b0;
    ab_le = 1'b0; ab_clk = 1'b0; ab_ce_n = 1'b1; ab_oe_n = 1'b0;
    ba_le = 1'b0; ba_clk = 1'b0; ba_ce_n = 1'b1; ba_oe_n = 1'b0;
    a_drv = '0; b_drv = '0; a_den = 1'b0; b_den = 1'b0;

    // R8: enables requested during reset stay inactive
    @(negedge clk);
    @(negedge clk);
    #2;
    chk(a_drv_en, '0, "R8 A released in reset");
    chk(b_drv_en, '0, "R8 B released in reset");
    pulse_ab();
    @(negedge clk);
    ab_oe_n = 1'b1;
    ba_oe_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    a_den = 1'b1;

    // A-to-B vector table
    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VECS[i]);
      @(negedge clk);
      ab_le = v.le;
      ab_ce_n = v.ce_n;
      ab_oe_n = v.oe_n;
      #1 a_drv = v.a;
      if (v.pulse) pulse_ab();
      #2;
      if (v.exp_off) begin
        chk(b_drv_en, '0, row_tag(i));
      end else begin
        chk(b_drv_en, '1, row_tag(i));
        chk(b_io, v.exp_b, row_tag(i));
      end
    end

    // R7: B-to-A direction
    @(negedge clk);
    ab_oe_n = 1'b1;
    a_den = 1'b0;
    b_den = 1'b1;
    ba_le = 1'b1;
    ba_ce_n = 1'b1;
    ba_oe_n = 1'b0;
    #1 b_drv = 18'h2F0F1;
    #2;
    chk(a_drv_en, '1, "R7 A driven");
    chk(a_io, 18'h2F0F1, "R7 transparent B to A");

    @(negedge clk);
    ba_le = 1'b0;
    #1 b_drv = 18'h1234A;
    #2;
    chk(a_io, 18'h2F0F1, "R7 hold B to A");

    @(negedge clk);
    ba_ce_n = 1'b0;
    #1;
    pulse_ba();
    #2;
    chk(a_io, 18'h1234A, "R7 load B to A");

    @(negedge clk);
    ba_ce_n = 1'b1;
    #1 b_drv = 18'h00001;
    pulse_ba();
    #2;
    chk(a_io, 18'h1234A, "R6 B to A edge ignored");

    @(negedge clk);
    ba_oe_n = 1'b1;
    #2;
    chk(a_drv_en, '0, "R7 A released");

    // R10: both directions enabled together, bench drivers off
    @(negedge clk);
    b_den = 1'b0;
    a_den = 1'b0;
    ab_oe_n = 1'b0;
    ba_oe_n = 1'b0;
    #2;
    chk(b_io, 18'h0F0F0, "R10 B shows A-to-B data");
    chk(a_io, 18'h1234A, "R10 A shows B-to-A data");
    @(negedge clk);
    #1;
    chk({{(W-1){1'b0}}, illegal_seen}, {{(W-1){1'b0}}, 1'b1}, "R10 illegal configuration flagged");
    ba_oe_n = 1'b1;

    // R8: reset in the middle of operation
    @(negedge clk);
    a_den = 1'b1;
    a_drv = 18'h3FFFF;
    #2;
    chk(b_io, 18'h0F0F0, "R3 B before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk(b_drv_en, '0, "R8 B released by reset");
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(b_drv_en, '1, "R8 B driven after reset");
    chk(b_io, 18'h00000, "R8 storage zero after reset");

    summary();
    $finish;
  end

endmodule